// File: doc/BRIEF.md
# Q-Branch False Lock Counter

This block watches the quadrature arm of a demodulator for the signature of a false lock. That signature appears when the carrier loop settles on square-wave data at high signal-to-noise ratio. Over each symbol it takes two integrals of the Q branch. One runs from end-bit to end-bit, which is the full symbol. The other runs from the previous end-bit to the mid-bit, which is the half symbol. A correct lock makes the full-symbol integral the larger of the two. When the full-symbol magnitude is the smaller one, the event is counted as a possible false lock.

The events go into a preloadable accumulator that restarts at every integration period boundary. A lock-control state machine elsewhere compares the accumulator's rollover against its own integration counter. If the rollover comes first, it declares false lock. A mode select can instead make the accumulator sum the magnitude of a frequency error detector output on each end-bit, in place of counting comparison events.

Top module: `flk_detector`

## Requirements
- R1: After reset, `count` is 0 and `rollover` is 0.
- R2: A cycle with `period_start` high loads `count` with `preload` and clears `rollover`; both are visible after that clock edge.
- R3: In count mode (`src_freq` = 0), an `end_bit` cycle whose full-symbol magnitude is strictly smaller than the latched half-symbol magnitude raises `count` by exactly 1 after that edge.
- R4: In count mode, an `end_bit` cycle with full-symbol magnitude equal to or larger than the latched half-symbol magnitude leaves `count` unchanged.
- R5: The comparison uses two's-complement magnitudes, so the signs of `q_full` and `q_half` have no effect, and the most negative code has magnitude 2^(Q_W-1).
- R6: The half-symbol value is captured only in a cycle with `mid_bit` high. Changes on `q_half` at other times do not affect later comparisons.
- R7: In frequency mode (`src_freq` = 1), each `end_bit` cycle adds the magnitude of `freq_err` to `count`, and the Q comparison has no effect.
- R8: In a cycle without `end_bit` and without `period_start`, `count` and `rollover` keep their values.
- R9: An addition that passes 2^ACC_W-1 wraps `count` modulo 2^ACC_W and sets `rollover`. `rollover` then stays high until the next `period_start`.
- R10: When `period_start` and `end_bit` are high in the same cycle, the load wins and the end-bit event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_full | input | Q_W | Signed Q integral over the full symbol |
| q_half | input | Q_W | Signed Q integral over the half symbol |
| end_bit | input | 1 | End-of-symbol strobe; triggers the comparison or the sum |
| mid_bit | input | 1 | Mid-symbol strobe; captures `q_half` |
| src_freq | input | 1 | 0: count comparison events, 1: sum frequency error magnitude |
| freq_err | input | F_W | Signed frequency error detector output |
| preload | input | ACC_W | Value loaded at the start of each period |
| period_start | input | 1 | Integration period boundary |
| count | output | ACC_W | Accumulator value |
| rollover | output | 1 | Sticky accumulator overflow flag |

## Verification
The comparison is tried with positive and negative operands, with the half-symbol value larger, equal and smaller, and with the most negative code. Together these separate a strict test from a non-strict one and a magnitude compare from a signed compare. Frequency mode is driven with operands for which the Q compare would count and with operands for which it would not, so the sum is shown to come from the frequency error alone. A stale-capture pattern changes `q_half` without a mid-bit strobe, which exposes a capture that is not gated by that strobe. Preloads just below the wrap point, followed by further events and a new period, show the wrap arithmetic, the sticky flag and its clearing, and a boundary that coincides with an end-bit shows the load taking priority.

// File: rtl/flk_pkg.sv
package flk_pkg;

    // Accumulator source select encoding
    typedef enum logic {
        FLK_SRC_CMP  = 1'b0,
        FLK_SRC_FREQ = 1'b1
    } flk_src_e;

    function automatic int flk_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/flk_mag.sv
// Two's-complement magnitude, one bit wider than the input so the most
// negative code is represented exactly.
module flk_mag #(
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    output logic [W:0]   mag
);
    logic [W:0] ext;

    always_comb begin
        ext = {din[W-1], din};
        if (din[W-1]) begin
            mag = ~ext + 1'b1;
        end else begin
            mag = ext;
        end
    end
endmodule

// File: rtl/flk_qcompare.sv
// Captures the half-symbol integral on mid_bit and compares magnitudes on end_bit.
module flk_qcompare #(
    parameter int Q_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mid_bit,
    input  logic           end_bit,
    input  logic [Q_W-1:0] q_full,
    input  logic [Q_W-1:0] q_half,
    output logic           hit
);
    typedef struct packed {
        logic [Q_W-1:0] half;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic [Q_W:0] full_mag;
    logic [Q_W:0] half_mag;

    flk_mag #(.W(Q_W)) u_full_mag (.din(q_full),  .mag(full_mag));
    flk_mag #(.W(Q_W)) u_half_mag (.din(st_q.half), .mag(half_mag));

    always_comb begin
        st_d = st_q;
        if (mid_bit) begin
            st_d.half = q_half;
        end
        hit = end_bit && (full_mag < half_mag);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: captured half value changes only on a mid-bit strobe
    p_half_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mid_bit |=> $stable(st_q.half));

    // R4: no event is reported outside an end-bit cycle
    p_hit_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !end_bit |-> !hit);
endmodule

// File: rtl/flk_accum.sv
// Preloadable accumulator with sticky carry-out flag.
module flk_accum #(
    parameter int ACC_W  = 10,
    parameter int STEP_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ACC_W-1:0]  preload,
    input  logic              step_en,
    input  logic [STEP_W-1:0] step,
    output logic [ACC_W-1:0]  count,
    output logic              rollover
);
    import flk_pkg::*;

    localparam int SUM_W = flk_max(ACC_W, STEP_W) + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             roll;
    } acc_state_t;

    acc_state_t   st_d, st_q;
    logic [SUM_W-1:0] sum;
    logic             carry;

    always_comb begin
        st_d  = st_q;
        sum   = {{(SUM_W-ACC_W){1'b0}}, st_q.acc} + {{(SUM_W-STEP_W){1'b0}}, step};
        carry = |sum[SUM_W-1:ACC_W];
        if (load) begin
            st_d.acc  = preload;
            st_d.roll = 1'b0;
        end else if (step_en) begin
            st_d.acc  = sum[ACC_W-1:0];
            st_d.roll = st_q.roll | carry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count    = st_q.acc;
    assign rollover = st_q.roll;

    // R2: load takes the preload and clears the flag
    p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(preload)) && !rollover);

    // R8: idle cycles keep state
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step_en) |=> $stable(count) && $stable(rollover));

    // R9: flag is sticky until a load
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rollover && !load) |=> rollover);
endmodule

// File: rtl/flk_detector.sv
module flk_detector #(
    parameter int Q_W   = 16,
    parameter int F_W   = 12,
    parameter int ACC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [Q_W-1:0]   q_full,
    input  logic [Q_W-1:0]   q_half,
    input  logic             end_bit,
    input  logic             mid_bit,
    input  logic             src_freq,
    input  logic [F_W-1:0]   freq_err,
    input  logic [ACC_W-1:0] preload,
    input  logic             period_start,
    output logic [ACC_W-1:0] count,
    output logic             rollover
);
    import flk_pkg::*;

    localparam int STEP_W = F_W + 1;

    flk_src_e         src;
    logic             hit;
    logic [F_W:0]     ferr_mag;
    logic [STEP_W-1:0] step;
    logic             step_en;

    flk_qcompare #(.Q_W(Q_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .mid_bit (mid_bit),
        .end_bit (end_bit),
        .q_full  (q_full),
        .q_half  (q_half),
        .hit     (hit)
    );

    flk_mag #(.W(F_W)) u_ferr_mag (.din(freq_err), .mag(ferr_mag));

    always_comb begin
        src = flk_src_e'(src_freq);
        if (src == FLK_SRC_FREQ) begin
            step    = ferr_mag;
            step_en = end_bit;
        end else begin
            step    = {{(STEP_W-1){1'b0}}, 1'b1};
            step_en = hit;
        end
    end

    flk_accum #(.ACC_W(ACC_W), .STEP_W(STEP_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (period_start),
        .preload  (preload),
        .step_en  (step_en),
        .step     (step),
        .count    (count),
        .rollover (rollover)
    );

    // R3: count mode moves the accumulator by at most one per end-bit
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_start && end_bit && !src_freq) |=>
            (count == $past(count) + 1'b1) || (count == $past(count)));

    // R10: boundary wins over a simultaneous end-bit
    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && end_bit) |=> count == $past(preload));
endmodule

// File: tb/flk_detector_bench.sv
module flk_detector_bench;
    localparam int Q_W   = 16;
    localparam int F_W   = 12;
    localparam int ACC_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [Q_W-1:0]   q_full = '0;
    logic [Q_W-1:0]   q_half = '0;
    logic             end_bit = 1'b0;
    logic             mid_bit = 1'b0;
    logic             src_freq = 1'b0;
    logic [F_W-1:0]   freq_err = '0;
    logic [ACC_W-1:0] preload = '0;
    logic             period_start = 1'b0;
    logic [ACC_W-1:0] count;
    logic             rollover;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    flk_detector #(.Q_W(Q_W), .F_W(F_W), .ACC_W(ACC_W)) u_flk_detector (
        .clk(clk), .rst_n(rst_n), .q_full(q_full), .q_half(q_half),
        .end_bit(end_bit), .mid_bit(mid_bit), .src_freq(src_freq),
        .freq_err(freq_err), .preload(preload), .period_start(period_start),
        .count(count), .rollover(rollover)
    );

    typedef struct packed {
        logic                    mode;
        logic signed [Q_W-1:0]   half;
        logic signed [Q_W-1:0]   full;
        logic signed [F_W-1:0]   fe;
        logic [ACC_W-1:0]        delta;
    } vec_t;

    localparam vec_t VECS [0:8] = '{
        '{1'b0,  16'sd100,    16'sd50,    12'sd0,    10'd1},   // R3
        '{1'b0,  16'sd100,    16'sd100,   12'sd0,    10'd0},   // R4 equal
        '{1'b0,  16'sd100,    16'sd150,   12'sd0,    10'd0},   // R4 larger
        '{1'b0, -16'sd100,    16'sd50,    12'sd0,    10'd1},   // R5 negative half
        '{1'b0,  16'sd100,   -16'sd99,    12'sd0,    10'd1},   // R5 negative full
        '{1'b0, -16'sd32768,  16'sd32767, 12'sd0,    10'd1},   // R5 most negative
        '{1'b1,  16'sd100,    16'sd50,   -12'sd37,   10'd37},  // R7 negative error
        '{1'b1,  16'sd10,     16'sd50,    12'sd200,  10'd200}, // R7 no compare event
        '{1'b0,  16'sd0,      16'sd0,     12'sd0,    10'd0}    // R4 zero
    };

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic boundary(input logic [ACC_W-1:0] p);
        preload = p;
        period_start = 1'b1;
        cyc();
        period_start = 1'b0;
    endtask

    task automatic mid(input logic [Q_W-1:0] h);
        q_half = h;
        mid_bit = 1'b1;
        cyc();
        mid_bit = 1'b0;
    endtask

    task automatic endb(input logic m, input logic [Q_W-1:0] f, input logic [F_W-1:0] fe);
        src_freq = m;
        q_full = f;
        freq_err = fe;
        end_bit = 1'b1;
        cyc();
        end_bit = 1'b0;
    endtask

    initial begin
        for (int n = 0; n < 100000; n++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc();
        rst_n = 1'b1;
        // R1: reset state
        check("R1 count", count, 0);
        check("R1 rollover", rollover, 0);

        // Vector table
        for (int i = 0; i < 9; i++) begin
            boundary(10'd5);
            check("R2 preload", count, 5);
            mid(VECS[i].half);
            endb(VECS[i].mode, VECS[i].full, VECS[i].fe);
            check($sformatf("R3/R4/R5/R7 vector %0d", i), count, 5 + VECS[i].delta);
        end

        // R6: q_half changes without mid_bit are ignored
        boundary(10'd0);
        mid(16'sd100);
        q_half = 16'sd1;
        cyc();
        endb(1'b0, 16'sd50, '0);
        check("R6 stale half", count, 1);

        // R8: no end_bit, inputs toggle, count holds
        q_full = 16'sd0;
        freq_err = 12'sd500;
        src_freq = 1'b1;
        cyc();
        cyc();
        check("R8 hold", count, 1);
        src_freq = 1'b0;

        // R9: wrap in count mode
        boundary(10'd1022);
        check("R2 rollover clear", rollover, 0);
        mid(16'sd100);
        endb(1'b0, 16'sd1, '0);
        check("R9 count 1023", count, 1023);
        check("R9 no roll yet", rollover, 0);
        endb(1'b0, 16'sd1, '0);
        check("R9 wrap count", count, 0);
        check("R9 roll set", rollover, 1);
        endb(1'b0, 16'sd1, '0);
        check("R9 after wrap", count, 1);
        check("R9 sticky", rollover, 1);
        boundary(10'd3);
        check("R2 reload", count, 3);
        check("R2 roll cleared", rollover, 0);

        // R9: wrap in frequency mode
        boundary(10'd1000);
        endb(1'b1, 16'sd0, 12'sd100);
        check("R9 freq wrap count", count, 76);
        check("R9 freq roll", rollover, 1);

        // R10: boundary and end_bit together
        boundary(10'd0);
        mid(16'sd100);
        preload = 10'd7;
        period_start = 1'b1;
        src_freq = 1'b0;
        q_full = 16'sd1;
        end_bit = 1'b1;
        cyc();
        period_start = 1'b0;
        end_bit = 1'b0;
        check("R10 load wins", count, 7);
        check("R10 roll clear", rollover, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule